// File: doc/BRIEF.md
# Up-Counting Timer with Buffered Prescaler

The block is a 16-bit up-counting timer driven from a single clock. A prescaler divides that clock down to a counter clock. Each counter clock tick advances the main counter. When the counter reaches a programmable reload limit it returns to zero and raises an update flag. A single compare channel raises its own flag when the counter lands on a programmed value. An interrupt request combines both flags with their enable bits.

The division ratio is double-buffered. Software writes a new divisor into a holding register, and the divider keeps running on its old ratio. The new ratio only becomes active on an update event: either a counter wrap or an update that software forces through the event register. Writing the counter directly changes only the count. So after reset, a divisor takes effect only once a wrap or a forced update has happened. Initialisation code is expected to force one update after programming the divisor.

Software reaches all state through a simple synchronous register port. A write takes effect at the clock edge where the write strobe is high. Reads are combinational from the selected address.

Top module: `upcnt_timer`

## Requirements
- R1: After reset, the counter, compare value, run bit, enables and both flags are 0. The active divisor and the held divisor (DIVPRE, address 5) are 0. The reload limit (RELOAD, address 6) is 0xFFFF.
- R2: While running, the counter advances by one on every (active divisor + 1)-th clock edge. The first advance comes (active divisor + 1) edges after an update event.
- R3: A write to DIVPRE (address 5) only updates the held divisor. The ratio in use is unchanged until the next update event.
- R4: On an update event, the held divisor is copied to the active divisor. In that same edge, the prescaler count and the counter both become 0.
- R5: A write to COUNT (address 4) loads the counter and nothing else. It is not an update event and sets no flag.
- R6: Once an update event has loaded a divisor, later COUNT writes leave the active division ratio unchanged.
- R7: A counter tick while the counter equals RELOAD returns the counter to 0. It is an update event and sets the update flag, STAT (address 2) bit 0.
- R8: The counter and the prescaler count advance only while CTRL (address 0) bit 0 is 1. While it is 0 they both hold.
- R9: Writing 1 to EVGEN (address 3) bit 0 forces an update event and sets STAT bit 0. EVGEN reads as 0.
- R10: When a counter tick carries the counter onto the CMP value (address 7), STAT bit 1 is set in the same edge.
- R11: Writing 0 to a STAT bit clears that flag and writing 1 leaves it unchanged. A flag set in the same cycle wins over the clear.
- R12: irq is high when (STAT bit 0 and IEN bit 0) or (STAT bit 1 and IEN bit 1). IEN is at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A register write lands on the edge where its strobe is high. It is visible on the combinational read path before the next edge.

With the counter stopped, an update leaves the counter at 0. After run is set, the first counter advance lands exactly (active divisor + 1) edges later. After N edges, the count is N divided by (divisor + 1), rounded down.

The wrap and compare flags change on the same edge as the counter value that causes them. The bench therefore reads counter, status and irq together, half a cycle after a counted number of edges.

// File: rtl/upcnt_timer_pkg.sv
package upcnt_timer_pkg;

    localparam int ADDR_W = 3;
    localparam int FLAG_W = 2;
    localparam int FLG_UPD = 0;
    localparam int FLG_CMP = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_IEN    = 3'd1,
        A_STAT   = 3'd2,
        A_EVGEN  = 3'd3,
        A_COUNT  = 3'd4,
        A_DIVPRE = 3'd5,
        A_RELOAD = 3'd6,
        A_CMP    = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/upcnt_prescale.sv
module upcnt_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         upd_evt,
    input  logic         pre_wr,
    input  logic [W-1:0] pre_wdata,
    output logic         tick,
    output logic [W-1:0] pre_q,
    output logic [W-1:0] act_q
);

    typedef struct packed {
        logic [W-1:0] pcnt;
        logic [W-1:0] act;
        logic [W-1:0] pre;
    } psc_t;

    psc_t st_d, st_q;

    assign tick  = run && (st_q.pcnt == st_q.act);
    assign pre_q = st_q.pre;
    assign act_q = st_q.act;

    always_comb begin
        st_d = st_q;
        if (pre_wr) begin
            st_d.pre = pre_wdata;
        end
        if (upd_evt) begin
            // transfer uses the value held before this cycle's write
            st_d.pcnt = '0;
            st_d.act  = st_q.pre;
        end else if (run) begin
            st_d.pcnt = tick ? '0 : st_q.pcnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/upcnt_counter.sv
module upcnt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         force_upd,
    input  logic         cnt_wr,
    input  logic         arr_wr,
    input  logic         cmp_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_q,
    output logic [W-1:0] arr_q,
    output logic [W-1:0] cmp_q,
    output logic         upd_evt,
    output logic         cmp_evt
);

    typedef struct packed {
        logic [W-1:0] count;
        logic [W-1:0] arr;
        logic [W-1:0] cmp;
    } cnt_t;

    cnt_t st_d, st_q;

    logic         wrap;
    logic         adv;
    logic [W-1:0] tick_val;

    // a software count write owns the cycle; its tick is dropped
    assign adv      = tick && !cnt_wr;
    assign wrap     = adv && (st_q.count == st_q.arr);
    assign tick_val = wrap ? '0 : st_q.count + W'(1);
    assign upd_evt  = force_upd || wrap;
    assign cmp_evt  = adv && !force_upd && (tick_val == st_q.cmp);

    assign count_q = st_q.count;
    assign arr_q   = st_q.arr;
    assign cmp_q   = st_q.cmp;

    always_comb begin
        st_d = st_q;
        if (arr_wr) begin
            st_d.arr = wdata;
        end
        if (cmp_wr) begin
            st_d.cmp = wdata;
        end
        if (cnt_wr) begin
            st_d.count = wdata;
        end else if (upd_evt) begin
            st_d.count = '0;
        end else if (adv) begin
            st_d.count = tick_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.arr   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/upcnt_regs.sv
module upcnt_regs
    import upcnt_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        wdata_lo,
    input  logic              upd_evt,
    input  logic              cmp_evt,
    input  logic [W-1:0]      count_q,
    input  logic [W-1:0]      arr_q,
    input  logic [W-1:0]      cmp_q,
    input  logic [W-1:0]      pre_q,
    output logic              run,
    output logic              cnt_wr,
    output logic              arr_wr,
    output logic              cmp_wr,
    output logic              pre_wr,
    output logic              force_upd,
    output logic [FLAG_W-1:0] flags,
    output logic [W-1:0]      rdata,
    output logic              irq
);

    typedef struct packed {
        logic              run;
        logic [FLAG_W-1:0] ien;
        logic [FLAG_W-1:0] flg;
    } ctl_t;

    ctl_t st_d, st_q;

    logic      wr_any;
    reg_addr_e addr;

    assign addr   = reg_addr_e'(bus_addr);
    assign wr_any = bus_sel && bus_wr;

    assign cnt_wr    = wr_any && (addr == A_COUNT);
    assign arr_wr    = wr_any && (addr == A_RELOAD);
    assign cmp_wr    = wr_any && (addr == A_CMP);
    assign pre_wr    = wr_any && (addr == A_DIVPRE);
    assign force_upd = wr_any && (addr == A_EVGEN) && wdata_lo[0];

    assign run   = st_q.run;
    assign flags = st_q.flg;
    assign irq   = |(st_q.flg & st_q.ien);

    always_comb begin
        st_d = st_q;
        if (wr_any && addr == A_CTRL) begin
            st_d.run = wdata_lo[0];
        end
        if (wr_any && addr == A_IEN) begin
            st_d.ien = wdata_lo;
        end
        if (wr_any && addr == A_STAT) begin
            st_d.flg = st_q.flg & wdata_lo;
        end
        // hardware set wins over a same-cycle clear
        if (upd_evt) begin
            st_d.flg[FLG_UPD] = 1'b1;
        end
        if (cmp_evt) begin
            st_d.flg[FLG_CMP] = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL:   rdata[0] = st_q.run;
            A_IEN:    rdata[FLAG_W-1:0] = st_q.ien;
            A_STAT:   rdata[FLAG_W-1:0] = st_q.flg;
            A_EVGEN:  rdata = '0;
            A_COUNT:  rdata = count_q;
            A_DIVPRE: rdata = pre_q;
            A_RELOAD: rdata = arr_q;
            A_CMP:    rdata = cmp_q;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/upcnt_timer.sv
module upcnt_timer
    import upcnt_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);

    logic              run_w;
    logic              tick_w;
    logic              upd_w;
    logic              cmp_evt_w;
    logic              cnt_wr_w;
    logic              arr_wr_w;
    logic              cmp_wr_w;
    logic              pre_wr_w;
    logic              force_w;
    logic [W-1:0]      count_w;
    logic [W-1:0]      arr_w;
    logic [W-1:0]      cmp_w;
    logic [W-1:0]      pre_w;
    logic [W-1:0]      act_w;
    logic [FLAG_W-1:0] flags_w;

    upcnt_prescale #(.W(W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .upd_evt   (upd_w),
        .pre_wr    (pre_wr_w),
        .pre_wdata (bus_wdata),
        .tick      (tick_w),
        .pre_q     (pre_w),
        .act_q     (act_w)
    );

    upcnt_counter #(.W(W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_w),
        .force_upd (force_w),
        .cnt_wr    (cnt_wr_w),
        .arr_wr    (arr_wr_w),
        .cmp_wr    (cmp_wr_w),
        .wdata     (bus_wdata),
        .count_q   (count_w),
        .arr_q     (arr_w),
        .cmp_q     (cmp_w),
        .upd_evt   (upd_w),
        .cmp_evt   (cmp_evt_w)
    );

    upcnt_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .wdata_lo  (bus_wdata[1:0]),
        .upd_evt   (upd_w),
        .cmp_evt   (cmp_evt_w),
        .count_q   (count_w),
        .arr_q     (arr_w),
        .cmp_q     (cmp_w),
        .pre_q     (pre_w),
        .run       (run_w),
        .cnt_wr    (cnt_wr_w),
        .arr_wr    (arr_wr_w),
        .cmp_wr    (cmp_wr_w),
        .pre_wr    (pre_wr_w),
        .force_upd (force_w),
        .flags     (flags_w),
        .rdata     (bus_rdata),
        .irq       (irq)
    );

endmodule

// File: rtl/upcnt_timer_chk.sv
module upcnt_timer_chk
    import upcnt_timer_pkg::*;
#(
    parameter int W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic              run,
    input logic              tick,
    input logic              upd,
    input logic [W-1:0]      count,
    input logic [W-1:0]      arr,
    input logic [W-1:0]      act,
    input logic [W-1:0]      pre,
    input logic [FLAG_W-1:0] flags,
    input logic              irq
);

    logic cnt_write;
    assign cnt_write = bus_sel && bus_wr && (bus_addr == A_COUNT);

    p_cnt_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_write |=> count == $past(bus_wdata));

    p_cnt_write_keeps_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_write |=> $stable(act));

    p_act_only_on_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(act));

    p_update_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (act == $past(pre)) && (count == '0));

    p_wrap_to_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_write && count == arr) |=> (count == '0) && flags[FLG_UPD]);

    p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_write && !upd) |=> $stable(count));

    p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

endmodule

bind upcnt_timer upcnt_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .run       (run_w),
    .tick      (tick_w),
    .upd       (upd_w),
    .count     (count_w),
    .arr       (arr_w),
    .act       (act_w),
    .pre       (pre_w),
    .flags     (flags_w),
    .irq       (irq)
);

// File: tb/upcnt_timer_test.sv
module upcnt_timer_test;
    import upcnt_timer_pkg::*;

    localparam int W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [W-1:0]      bus_wdata = '0;
    logic [W-1:0]      bus_rdata;
    logic              irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    upcnt_timer #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // {divisor, edges to run}
    localparam logic [31:0] VECS [5] = '{
        {16'd0,  16'd10},
        {16'd3,  16'd20},
        {16'd15, 16'd64},
        {16'd1,  16'd7},
        {16'd4,  16'd23}
    };

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input reg_addr_e a, input logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, output logic [W-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
    endtask

    // stop, load divisor via forced update, clear flags
    task automatic setup(input logic [W-1:0] div);
        wr(A_CTRL, 16'd0);
        wr(A_DIVPRE, div);
        wr(A_EVGEN, 16'd1);
        wr(A_STAT, 16'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_COUNT, v);  check("R1 count", v, 16'h0);
        rd(A_RELOAD, v); check("R1 reload", v, 16'hFFFF);
        rd(A_DIVPRE, v); check("R1 divpre", v, 16'h0);
        rd(A_STAT, v);   check("R1 stat", v, 16'h0);
        rd(A_CTRL, v);   check("R1 ctrl", v, 16'h0);
        check("R1 irq", {15'd0, irq}, 16'd0);

        // R2 division ratio table
        for (int i = 0; i < 5; i++) begin
            logic [W-1:0] div;
            int n;
            div = VECS[i][31:16];
            n = int'(VECS[i][15:0]);
            setup(div);
            wr(A_CTRL, 16'd1);
            edges(n);
            rd(A_COUNT, v);
            check("R2 ratio", v, W'(n / (int'(div) + 1)));
        end

        // R3/R5 held divisor not applied by a count write
        setup(16'd0);
        wr(A_DIVPRE, 16'd15);
        wr(A_COUNT, 16'd0);
        rd(A_STAT, v); check("R5 no flag from count write", v, 16'd0);
        wr(A_CTRL, 16'd1);
        edges(32);
        rd(A_COUNT, v); check("R3 old ratio kept", v, 16'd32);

        // R7/R4 wrap applies held divisor
        setup(16'd0);
        wr(A_RELOAD, 16'd3);
        wr(A_DIVPRE, 16'd1);
        wr(A_STAT, 16'd0);
        wr(A_CTRL, 16'd1);
        edges(4);
        rd(A_COUNT, v); check("R7 wrap to zero", v, 16'd0);
        rd(A_STAT, v);  check("R7 update flag", v & 16'd1, 16'd1);
        edges(4);
        rd(A_COUNT, v); check("R4 new ratio after wrap", v, 16'd2);

        // R6/R8 count write after load keeps ratio; stop holds prescaler
        wr(A_CTRL, 16'd0);
        wr(A_DIVPRE, 16'd5);
        wr(A_COUNT, 16'd0);
        wr(A_CTRL, 16'd1);
        edges(6);
        rd(A_COUNT, v); check("R6 ratio kept after count write", v, 16'd3);

        // R10/R12 compare flag and irq
        wr(A_RELOAD, 16'hFFFF);
        setup(16'd0);
        wr(A_CMP, 16'd5);
        wr(A_IEN, 16'd2);
        wr(A_CTRL, 16'd1);
        edges(4);
        rd(A_STAT, v); check("R10 no flag before match", v & 16'd2, 16'd0);
        check("R12 irq low before match", {15'd0, irq}, 16'd0);
        edges(1);
        rd(A_COUNT, v); check("R10 count at match", v, 16'd5);
        rd(A_STAT, v);  check("R10 compare flag", v & 16'd2, 16'd2);
        check("R12 irq on compare", {15'd0, irq}, 16'd1);

        // R12 enable off masks irq; R11 clear rules
        wr(A_IEN, 16'd0);
        check("R12 irq masked", {15'd0, irq}, 16'd0);
        wr(A_CTRL, 16'd0);
        wr(A_STAT, 16'd3);
        rd(A_STAT, v); check("R11 write one keeps", v & 16'd2, 16'd2);
        wr(A_STAT, 16'd0);
        rd(A_STAT, v); check("R11 write zero clears", v, 16'd0);

        // R9 forced update restarts count and sets flag
        wr(A_IEN, 16'd1);
        wr(A_EVGEN, 16'd1);
        rd(A_COUNT, v); check("R9 count restarted", v, 16'd0);
        rd(A_STAT, v);  check("R9 update flag", v, 16'd1);
        rd(A_EVGEN, v); check("R9 evgen reads zero", v, 16'd0);
        check("R12 irq on update", {15'd0, irq}, 16'd1);

        // R8 stopped counter holds
        wr(A_COUNT, 16'd7);
        edges(10);
        rd(A_COUNT, v); check("R8 hold while stopped", v, 16'd7);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule